// File: doc/BRIEF.md
# Short Conditional Branch Resolver

This block settles the outcome of a short relative branch at the decode stage. It takes the opcode byte that was fetched, the signed 8-bit displacement that follows it, the address of the next sequential instruction, the five status flags (carry, zero, sign, overflow, parity) and the count register. It reports whether the branch is taken and which instruction address comes next.

Sixteen flag-tested conditions sit in the opcode range 0x70 to 0x7F. The condition is chosen by the low nibble, and bit 0 of that nibble inverts the test. Opcode 0xE3 tests the count register for zero instead of the flags, over either 32 or 16 bits. Opcode 0xEB is an unconditional short jump. A 16-bit operand size truncates a taken target to its low half. Any other opcode is flagged as invalid. Each result is registered and appears one cycle after the request strobe.

Top module: `sbr_resolver`

## Requirements
- R1: While rst_ni is low, and until the first request after reset, valid_o, taken_o and invalid_o are 0 and target_o is 0.
- R2: A request with valid_i=1 produces valid_o=1 on the next cycle. When valid_i=0, the next cycle has valid_o=0, and taken_o, invalid_o and target_o keep their previous values.
- R3: Opcodes 0x70..0x7F test a base condition chosen by opcode bits [3:1]. The mapping is: 0 overflow (OF=1), 1 carry (CF=1), 2 zero (ZF=1), 3 CF=1 or ZF=1, 4 sign (SF=1), 5 parity (PF=1), 6 SF!=OF, 7 ZF=1 or SF!=OF. When opcode bit 0 is 0, the branch is taken exactly when the base condition holds.
- R4: For an odd opcode in 0x70..0x7F, taken_o is the complement of the base condition of its even partner. For example, 0x77 is taken iff CF=0 and ZF=0, and 0x7F is taken iff ZF=0 and SF=OF.
- R5: Opcode 0xE3 is taken exactly when the count register is zero, whatever the flags. The test covers the low 16 bits when addrsize16_i=1 and all 32 bits otherwise.
- R6: Opcode 0xEB is always taken.
- R7: A taken target is next_ip_i plus the displacement sign-extended to 32 bits, modulo 2^32.
- R8: When opsize16_i=1, a taken target has bits [31:16] cleared.
- R9: When the branch is not taken, target_o equals next_ip_i, with no truncation.
- R10: Any opcode other than 0x70..0x7F, 0xE3 and 0xEB gives invalid_o=1 and taken_o=0. For the supported opcodes invalid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Branch opcode byte |
| disp_i | input | 8 | Signed displacement |
| next_ip_i | input | 32 | Address of the following instruction |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| pf_i | input | 1 | Parity flag |
| count_i | input | 32 | Count register |
| opsize16_i | input | 1 | 16-bit operand size, truncates taken target |
| addrsize16_i | input | 1 | 16-bit address size, narrows count test |
| valid_o | output | 1 | Result strobe |
| taken_o | output | 1 | Branch taken |
| invalid_o | output | 1 | Unsupported opcode |
| target_o | output | 32 | Next instruction address |

## Verification
Several properties compare registered outputs with the inputs seen one edge earlier through $past. They assume every input is stable and fully driven across each edge where valid_i is high. The bench meets this by changing all inputs only on the falling edge and by keeping valid_i high through a whole sweep. The hold property assumes that the outputs are left alone while the strobe is low. The bench exercises this with an idle cycle between bursts, during which the inputs are scrambled.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    KIND_COND   = 2'd0,
    KIND_CNTZ   = 2'd1,
    KIND_ALWAYS = 2'd2,
    KIND_BAD    = 2'd3
  } br_kind_e;

  localparam logic [3:0] COND_ROW = 4'h7;
  localparam logic [7:0] OP_CNTZ  = 8'hE3;
  localparam logic [7:0] OP_JMP   = 8'hEB;
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
(
  input  logic [7:0] opcode_i,
  output br_kind_e   kind_o,
  output logic [3:0] sel_o
);
  assign sel_o = opcode_i[3:0];

  always_comb begin
    if (opcode_i[7:4] == COND_ROW)  kind_o = KIND_COND;
    else if (opcode_i == OP_CNTZ)   kind_o = KIND_CNTZ;
    else if (opcode_i == OP_JMP)    kind_o = KIND_ALWAYS;
    else                            kind_o = KIND_BAD;
  end
endmodule

// File: rtl/sbr_cond.sv
module sbr_cond (
  input  logic [3:0] sel_i,
  input  logic       cf_i,
  input  logic       zf_i,
  input  logic       sf_i,
  input  logic       of_i,
  input  logic       pf_i,
  output logic       hit_o
);
  logic base;
  logic lt;

  assign lt = sf_i ^ of_i;

  always_comb begin
    unique case (sel_i[3:1])
      3'd0: base = of_i;
      3'd1: base = cf_i;
      3'd2: base = zf_i;
      3'd3: base = cf_i | zf_i;
      3'd4: base = sf_i;
      3'd5: base = pf_i;
      3'd6: base = lt;
      3'd7: base = zf_i | lt;
      default: base = 1'b0;
    endcase
  end

  // odd opcode tests the complement of its even partner
  assign hit_o = base ^ sel_i[0];
endmodule

// File: rtl/sbr_target.sv
module sbr_target #(
  parameter int IP_W    = 32,
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 16
) (
  input  logic [IP_W-1:0]   next_ip_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              opsize16_i,
  input  logic              take_i,
  output logic [IP_W-1:0]   target_o
);
  localparam int EXT_W = IP_W - DISP_W;
  localparam int HI_W  = IP_W - SHORT_W;

  logic [IP_W-1:0] disp_ext;
  logic [IP_W-1:0] sum;
  logic [IP_W-1:0] jump_ip;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign sum      = next_ip_i + disp_ext;
  assign jump_ip  = opsize16_i ? {{HI_W{1'b0}}, sum[SHORT_W-1:0]} : sum;
  assign target_o = take_i ? jump_ip : next_ip_i;
endmodule

// File: rtl/sbr_resolver.sv
module sbr_resolver
  import sbr_pkg::*;
#(
  parameter int IP_W    = 32,
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [IP_W-1:0]   next_ip_i,
  input  logic              cf_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              of_i,
  input  logic              pf_i,
  input  logic [IP_W-1:0]   count_i,
  input  logic              opsize16_i,
  input  logic              addrsize16_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic              invalid_o,
  output logic [IP_W-1:0]   target_o
);
  br_kind_e        kind;
  logic [3:0]      sel;
  logic            cond_hit;
  logic            cnt_zero;
  logic            take_d;
  logic            bad_d;
  logic [IP_W-1:0] target_d;

  sbr_decode u_decode (
    .opcode_i (opcode_i),
    .kind_o   (kind),
    .sel_o    (sel)
  );

  sbr_cond u_cond (
    .sel_i (sel),
    .cf_i  (cf_i),
    .zf_i  (zf_i),
    .sf_i  (sf_i),
    .of_i  (of_i),
    .pf_i  (pf_i),
    .hit_o (cond_hit)
  );

  assign cnt_zero = addrsize16_i ? (count_i[SHORT_W-1:0] == '0) : (count_i == '0);

  always_comb begin
    unique case (kind)
      KIND_COND:   take_d = cond_hit;
      KIND_CNTZ:   take_d = cnt_zero;
      KIND_ALWAYS: take_d = 1'b1;
      default:     take_d = 1'b0;
    endcase
  end

  assign bad_d = (kind == KIND_BAD);

  sbr_target #(
    .IP_W    (IP_W),
    .DISP_W  (DISP_W),
    .SHORT_W (SHORT_W)
  ) u_target (
    .next_ip_i  (next_ip_i),
    .disp_i     (disp_i),
    .opsize16_i (opsize16_i),
    .take_i     (take_d),
    .target_o   (target_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      invalid_o <= 1'b0;
      target_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= take_d;
        invalid_o <= bad_d;
        target_o  <= target_d;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(target_o) && $stable(taken_o) && $stable(invalid_o)));

  // R10
  bad_not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !taken_o);

  // R6
  jmp_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(opcode_i) == OP_JMP) |-> taken_o);

  // R5
  cntz16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(opcode_i) == OP_CNTZ && $past(addrsize16_i))
      |-> (taken_o == ($past(count_i[SHORT_W-1:0]) == '0)));

  // R8
  short_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o && $past(opsize16_i)) |-> (target_o[IP_W-1:SHORT_W] == '0));

  // R9
  fallthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |-> (target_o == $past(next_ip_i)));
endmodule

// File: tb/sbr_resolver_test.sv
module sbr_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid;
  logic [7:0]  opcode;
  logic [7:0]  disp;
  logic [31:0] next_ip;
  logic        cf, zf, sf, of, pf;
  logic [31:0] count;
  logic        opsize16, addrsize16;
  logic        valid_o, taken_o, invalid_o;
  logic [31:0] target_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sbr_resolver uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opcode),
    .disp_i(disp), .next_ip_i(next_ip), .cf_i(cf), .zf_i(zf), .sf_i(sf),
    .of_i(of), .pf_i(pf), .count_i(count), .opsize16_i(opsize16),
    .addrsize16_i(addrsize16), .valid_o(valid_o), .taken_o(taken_o),
    .invalid_o(invalid_o), .target_o(target_o)
  );

  function automatic bit ref_cond(input logic [3:0] n, input logic c, z, s, o, p);
    case (n)
      4'h0: return o;
      4'h1: return !o;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return z;
      4'h5: return !z;
      4'h6: return c || z;
      4'h7: return !c && !z;
      4'h8: return s;
      4'h9: return !s;
      4'hA: return p;
      4'hB: return !p;
      4'hC: return s != o;
      4'hD: return s == o;
      4'hE: return z || (s != o);
      default: return !z && (s == o);
    endcase
  endfunction

  // drive at negedge, registered result checked at the following negedge
  task automatic apply_check();
    bit          e_take, e_bad;
    logic [31:0] e_tgt;
    string       tag;
    @(negedge clk);
    e_bad = 1'b0;
    if (opcode[7:4] == 4'h7) begin
      e_take = ref_cond(opcode[3:0], cf, zf, sf, of, pf);
      tag = opcode[0] ? "R4" : "R3";
    end else if (opcode == 8'hE3) begin
      e_take = addrsize16 ? (count % 65536 == 0) : (count == 0);
      tag = "R5";
    end else if (opcode == 8'hEB) begin
      e_take = 1'b1;
      tag = "R6";
    end else begin
      e_take = 1'b0;
      e_bad = 1'b1;
      tag = "R10";
    end
    if (e_take) begin
      e_tgt = next_ip + 32'($signed(disp));
      if (opsize16) e_tgt = e_tgt % 65536;
    end else begin
      e_tgt = next_ip;
    end
    @(negedge clk);
    vectors++;
    if (valid_o !== 1'b1 || taken_o !== e_take || invalid_o !== e_bad) begin
      fails++;
      $display("FAIL %s op=%02h v/t/i actual=%b%b%b expected=1%b%b", tag, opcode,
               valid_o, taken_o, invalid_o, e_take, e_bad);
    end else if (target_o !== e_tgt) begin
      fails++;
      $display("FAIL %s op=%02h target actual=%08h expected=%08h",
               !e_take ? "R9" : (opsize16 ? "R8" : "R7"), opcode, target_o, e_tgt);
    end
  endtask

  task automatic idle_check();
    logic [31:0] t0;
    bit          k0, b0;
    t0 = target_o; k0 = taken_o; b0 = invalid_o;
    valid = 1'b0;
    opcode = 8'hEB; disp = 8'h55; next_ip = ~next_ip; opsize16 = 1'b0;
    @(negedge clk);
    vectors++;
    if (valid_o !== 1'b0 || target_o !== t0 || taken_o !== k0 || invalid_o !== b0) begin
      fails++;
      $display("FAIL R2 idle actual v=%b t=%b tgt=%08h expected v=0 t=%b tgt=%08h",
               valid_o, taken_o, target_o, k0, t0);
    end
    valid = 1'b1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    valid = 0; opcode = 0; disp = 0; next_ip = 0; count = 0;
    {cf, zf, sf, of, pf} = '0; opsize16 = 0; addrsize16 = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (valid_o !== 0 || taken_o !== 0 || invalid_o !== 0 || target_o !== 0) begin
      fails++;
      $display("FAIL R1 reset actual=%b%b%b %08h expected=000 00000000",
               valid_o, taken_o, invalid_o, target_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (valid_o !== 0 || target_o !== 0) begin
      fails++;
      $display("FAIL R1 post-reset actual v=%b tgt=%08h expected v=0 tgt=0", valid_o, target_o);
    end

    // full opcode x flag sweep, both operand sizes
    for (int sz = 0; sz < 2; sz++) begin
      for (int op = 0; op < 256; op++) begin
        for (int f = 0; f < 32; f++) begin
          valid = 1'b1;
          opcode = 8'(op);
          {cf, zf, sf, of, pf} = 5'(f);
          disp = 8'(op * 7 + f * 13);
          next_ip = f[0] ? 32'hFFFF_FFA0 + 32'(op) : 32'h0001_2340 ^ {16'h0, 8'(op), 8'h0};
          count = 32'(f);
          opsize16 = sz[0];
          addrsize16 = f[1];
          apply_check();
        end
      end
      idle_check();
    end

    // count-zero branch over both widths and mixed flags
    for (int c = 0; c < 6; c++) begin
      for (int a = 0; a < 2; a++) begin
        for (int f = 0; f < 32; f += 7) begin
          logic [31:0] cv [6] = '{32'h0, 32'h0001_0000, 32'h1, 32'hFFFF_0000, 32'h8000_0000, 32'h0000_8000};
          opcode = 8'hE3;
          count = cv[c];
          addrsize16 = a[0];
          {cf, zf, sf, of, pf} = 5'(f);
          disp = 8'h80;
          next_ip = 32'h0000_0050;
          opsize16 = f[0];
          apply_check();
        end
      end
    end

    // displacement extremes
    for (int d = 0; d < 256; d += 17) begin
      opcode = 8'hEB; disp = 8'(d); next_ip = 32'h0000_FFF0; opsize16 = 0;
      apply_check();
      opsize16 = 1;
      apply_check();
    end
    idle_check();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule